// File: doc/BRIEF.md
# Serial Control Register Interface

This block is the register-access engine behind a serial control port that moves 16-bit frames. It generates the port's serial clock from the master clock. It captures host frames on the rising serial-clock edge and turns each one into a register write. Each frame carries a 10-bit data word in its upper bits and a 6-bit location in its lower bits, and the most significant bit comes first. The register map has 27 locations, and only thirteen of them are backed by storage.

Reads are indirect. The host writes a target location into one of two read-pointer registers. A short delay later, the block sends a reply frame of its own on a separate data-out line. The reply uses the same layout as a write: the 10 data bits of the target, then the target's 6-bit location. A frame-sync output marks the first bit of the reply.

Each register belongs to one of three reset classes: cleared only by the reset pin, cleared by the auxiliary soft reset, or cleared by the baseband soft reset. Each soft reset is triggered by a bit that clears itself. One of the clock-rate registers sets the serial-clock divider.

Top module: `ser_reg_if`

## Requirements
- R1: A frame is 16 bits, sent most significant bit first. `rx_fs` is high while bit 15 is sampled. Frame bits 15..6 hold the data word and bits 5..0 hold the location. The block samples `rx_sd` on the rising edge of `sclk_o`, and `tx_sd` changes only on its falling edge.
- R2: Locations 3, 4, 7, 8, 9, 10, 12, 18, 19, 20, 21, 25 and 26 store the written data. Locations 9 and 10 keep only the 6 low data bits. A write to any other location has no effect.
- R3: Writing location 9 or 10 starts a read. The target location is taken from data bits 5..0 (frame bits 11..6), and data bits 9..6 are ignored. The reply frame is {target data, target location}. An unmapped or out-of-range target returns zero data.
- R4: The reply starts on a falling edge of `sclk_o`, no sooner than 4 master clocks after the pointer write is captured. `tx_fs` is high only for the reply's first bit.
- R5: After the reset pin is released, every register is zero except locations 25 and 26, which hold 4. `tx_fs`, `tx_sd` and `sclk_o` are low while reset is held.
- R6: The period of `sclk_o` is 2 × R master clocks, where R is the value in location 26. A value of 0 acts as 1.
- R7: Writing location 19 with data bit 0 set clears locations 12, 18 and 19. The clear lasts 4 master clocks, and writes to those locations during that time are ignored.
- R8: Writing location 20 with data bit 7 set clears locations 3, 4, 7, 8, 20 and 21. The clear lasts 8 master clocks.
- R9: Neither soft reset changes locations 9, 10, 25 or 26. Both trigger bits read back as zero, and a soft reset leaves the other class's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset pin, clears all reset classes |
| sclk_o | output | 1 | Serial clock generated for the port |
| rx_fs | input | 1 | Host frame sync, high during the first bit of a host frame |
| rx_sd | input | 1 | Host serial data into the block |
| tx_fs | output | 1 | Reply frame sync, high during the first bit of a reply |
| tx_sd | output | 1 | Reply serial data out of the block |

## Verification
The hardest case to reach is a soft reset that must clear one class of registers and leave the other class, the read pointers and the clock-rate registers untouched. Every location is visible only through a full pointer-write and reply round trip. The stimulus therefore first loads distinct values into registers of both classes and into location 25. It then fires one soft reset and reads every affected and unaffected location back. The divider is also driven to its fastest setting, with a rate of zero, and a read round trip is completed at that rate, so the capture and reply paths are exercised with a two-clock serial period.

// File: rtl/ser_reg_pkg.sv
package ser_reg_pkg;

   // Frame geometry
   localparam int FRM_DATA_W = 10;
   localparam int FRM_LOC_W  = 6;

   // Locations whose behaviour other logic depends on
   localparam int LOC_PTR_A   = 9;
   localparam int LOC_PTR_B   = 10;
   localparam int LOC_AUX_CTL = 19;
   localparam int LOC_BB_CTL  = 20;
   localparam int LOC_RATE_A  = 25;
   localparam int LOC_RATE_B  = 26;
   localparam int MAP_SIZE    = 27;

   // Self-clearing trigger bits
   localparam int AUX_TRIG_BIT = 0;
   localparam int BB_TRIG_BIT  = 7;

   typedef enum logic [1:0] {
      RC_NONE,
      RC_PIN,
      RC_AUX,
      RC_BB
   } rst_class_e;

   function automatic rst_class_e class_of(input int loc);
      case (loc)
         3, 4, 7, 8, 20, 21: return RC_BB;
         12, 18, 19:         return RC_AUX;
         9, 10, 25, 26:      return RC_PIN;
         default:            return RC_NONE;
      endcase
   endfunction

   function automatic bit is_ptr_loc(input int loc);
      return (loc == LOC_PTR_A) || (loc == LOC_PTR_B);
   endfunction

   function automatic bit is_rate_loc(input int loc);
      return (loc == LOC_RATE_A) || (loc == LOC_RATE_B);
   endfunction

endpackage

// File: rtl/ser_sclk_gen.sv
module ser_sclk_gen #(
   parameter int RATE_W     = 10,
   parameter int RESET_RATE = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RATE_W-1:0] rate,
   output logic              sclk,
   output logic              rise_stb,
   output logic              fall_stb
);

   if (RESET_RATE < 1 || RESET_RATE >= (1 << RATE_W)) begin : g_bad_rate
      $error("ser_sclk_gen: RESET_RATE out of range");
   end

   logic [RATE_W-1:0] half_cnt;
   logic [RATE_W-1:0] eff_rate;
   logic              toggle;

   assign eff_rate = (rate == '0) ? RATE_W'(1) : rate;
   assign toggle   = (half_cnt == '0);
   assign rise_stb = toggle & ~sclk;
   assign fall_stb = toggle &  sclk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_cnt <= RATE_W'(RESET_RATE - 1);
         sclk     <= 1'b0;
      end else if (toggle) begin
         half_cnt <= eff_rate - RATE_W'(1);
         sclk     <= ~sclk;
      end else begin
         half_cnt <= half_cnt - RATE_W'(1);
      end
   end

endmodule

// File: rtl/ser_frame_rx.sv
module ser_frame_rx #(
   parameter int FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sample_en,
   input  logic               fs,
   input  logic               sd,
   output logic               frm_vld,
   output logic [FRAME_W-1:0] frm
);

   localparam int CNT_W = $clog2(FRAME_W);

   if (FRAME_W < 4) begin : g_bad_frame
      $error("ser_frame_rx: FRAME_W too small");
   end

   logic [FRAME_W-1:0] shreg;
   logic [FRAME_W-1:0] shreg_nxt;
   logic [CNT_W-1:0]   bit_cnt;
   logic               active;

   assign shreg_nxt = {shreg[FRAME_W-2:0], sd};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg   <= '0;
         bit_cnt <= '0;
         active  <= 1'b0;
         frm_vld <= 1'b0;
         frm     <= '0;
      end else begin
         frm_vld <= 1'b0;
         if (sample_en) begin
            shreg <= shreg_nxt;
            if (fs) begin
               active  <= 1'b1;
               bit_cnt <= CNT_W'(1);
            end else if (active) begin
               if (bit_cnt == CNT_W'(FRAME_W - 1)) begin
                  active  <= 1'b0;
                  bit_cnt <= '0;
                  frm_vld <= 1'b1;
                  frm     <= shreg_nxt;
               end else begin
                  bit_cnt <= bit_cnt + CNT_W'(1);
               end
            end
         end
      end
   end

endmodule

// File: rtl/ser_reg_file.sv
module ser_reg_file
   import ser_reg_pkg::*;
#(
   parameter int DATA_W      = 10,
   parameter int ADDR_W      = 6,
   parameter int NUM_LOC     = 27,
   parameter int AUX_RST_CYC = 4,
   parameter int BB_RST_CYC  = 8,
   parameter int RATE_RESET  = 4,
   parameter int RATE_LOC    = 26
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_vld,
   input  logic [ADDR_W-1:0] wr_loc,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_loc,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] rate_val,
   output logic              aux_clr,
   output logic              bb_clr,
   output logic [DATA_W-1:0] regs_v [NUM_LOC]
);

   localparam int AC_W = $clog2(AUX_RST_CYC + 1);
   localparam int BC_W = $clog2(BB_RST_CYC + 1);

   if (NUM_LOC < MAP_SIZE || NUM_LOC > (1 << ADDR_W)) begin : g_bad_map
      $error("ser_reg_file: NUM_LOC does not fit the map");
   end
   if (DATA_W <= BB_TRIG_BIT || ADDR_W > DATA_W) begin : g_bad_width
      $error("ser_reg_file: widths too small for the trigger bits");
   end
   if (!is_rate_loc(RATE_LOC)) begin : g_bad_rate_loc
      $error("ser_reg_file: RATE_LOC must name a clock-rate register");
   end
   if (AUX_RST_CYC < 1 || BB_RST_CYC < 1) begin : g_bad_cyc
      $error("ser_reg_file: soft reset length must be at least one cycle");
   end

   logic            aux_go;
   logic            bb_go;
   logic [AC_W-1:0] aux_cnt;
   logic [BC_W-1:0] bb_cnt;

   assign aux_go  = wr_vld && (wr_loc == ADDR_W'(LOC_AUX_CTL)) && wr_data[AUX_TRIG_BIT];
   assign bb_go   = wr_vld && (wr_loc == ADDR_W'(LOC_BB_CTL))  && wr_data[BB_TRIG_BIT];
   assign aux_clr = aux_go || (aux_cnt != '0);
   assign bb_clr  = bb_go  || (bb_cnt  != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         aux_cnt <= '0;
         bb_cnt  <= '0;
      end else begin
         if (aux_go)               aux_cnt <= AC_W'(AUX_RST_CYC - 1);
         else if (aux_cnt != '0)   aux_cnt <= aux_cnt - AC_W'(1);
         if (bb_go)                bb_cnt  <= BC_W'(BB_RST_CYC - 1);
         else if (bb_cnt != '0)    bb_cnt  <= bb_cnt - BC_W'(1);
      end
   end

   for (genvar i = 0; i < NUM_LOC; i++) begin : g_loc
      localparam rst_class_e RC = class_of(i);
      if (RC == RC_NONE) begin : g_unmapped
         assign regs_v[i] = '0;
      end else begin : g_mapped
         localparam logic [DATA_W-1:0] MASK =
            is_ptr_loc(i) ? DATA_W'((1 << ADDR_W) - 1) : {DATA_W{1'b1}};
         localparam logic [DATA_W-1:0] RSTV =
            is_rate_loc(i) ? DATA_W'(RATE_RESET) : '0;
         logic              soft_clr;
         logic [DATA_W-1:0] q;
         if (RC == RC_AUX) begin : g_aux
            assign soft_clr = aux_clr;
         end else if (RC == RC_BB) begin : g_bb
            assign soft_clr = bb_clr;
         end else begin : g_pin
            assign soft_clr = 1'b0;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= RSTV;
            else if (soft_clr)
               q <= '0;
            else if (wr_vld && (wr_loc == ADDR_W'(i)))
               q <= wr_data & MASK;
         end
         assign regs_v[i] = q;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NUM_LOC; k++) begin
         if (rd_loc == ADDR_W'(k)) rd_data = regs_v[k];
      end
   end

   assign rate_val = regs_v[RATE_LOC];

endmodule

// File: rtl/ser_frame_tx.sv
module ser_frame_tx #(
   parameter int DATA_W   = 10,
   parameter int ADDR_W   = 6,
   parameter int RD_DELAY = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [ADDR_W-1:0] req_loc,
   input  logic              shift_en,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] rd_loc,
   output logic              tx_fs,
   output logic              tx_sd
);

   localparam int FRAME_W = DATA_W + ADDR_W;
   localparam int BC_W    = $clog2(FRAME_W);
   localparam int DLY_W   = $clog2(RD_DELAY + 1);

   if (RD_DELAY < 1) begin : g_bad_delay
      $error("ser_frame_tx: RD_DELAY must be at least 1");
   end

   logic [FRAME_W-1:0] shreg;
   logic [BC_W-1:0]    bits_left;
   logic [DLY_W-1:0]   dly;
   logic               armed;
   logic               busy;

   assign tx_sd = shreg[FRAME_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg     <= '0;
         bits_left <= '0;
         dly       <= '0;
         armed     <= 1'b0;
         busy      <= 1'b0;
         tx_fs     <= 1'b0;
         rd_loc    <= '0;
      end else begin
         if (req) begin
            rd_loc <= req_loc;
            armed  <= 1'b1;
            dly    <= DLY_W'(RD_DELAY - 1);
         end else if (dly != '0) begin
            dly <= dly - DLY_W'(1);
         end
         if (shift_en) begin
            if (busy) begin
               tx_fs <= 1'b0;
               shreg <= {shreg[FRAME_W-2:0], 1'b0};
               if (bits_left == '0) busy <= 1'b0;
               else                 bits_left <= bits_left - BC_W'(1);
            end else if (armed && (dly == '0) && !req) begin
               shreg     <= {rd_data, rd_loc};
               tx_fs     <= 1'b1;
               busy      <= 1'b1;
               armed     <= 1'b0;
               bits_left <= BC_W'(FRAME_W - 1);
            end
         end
      end
   end

endmodule

// File: rtl/ser_reg_if.sv
module ser_reg_if
   import ser_reg_pkg::*;
#(
   parameter int DATA_W      = FRM_DATA_W,
   parameter int ADDR_W      = FRM_LOC_W,
   parameter int NUM_LOC     = MAP_SIZE,
   parameter int RD_DELAY    = 4,
   parameter int AUX_RST_CYC = 4,
   parameter int BB_RST_CYC  = 8,
   parameter int RATE_RESET  = 4,
   parameter int RATE_LOC    = LOC_RATE_B
) (
   input  logic clk,
   input  logic rst_n,
   output logic sclk_o,
   input  logic rx_fs,
   input  logic rx_sd,
   output logic tx_fs,
   output logic tx_sd
);

   localparam int FRAME_W = DATA_W + ADDR_W;

   logic               rise_stb;
   logic               fall_stb;
   logic               frm_vld;
   logic [FRAME_W-1:0] frm;
   logic [DATA_W-1:0]  wr_data;
   logic [ADDR_W-1:0]  wr_loc;
   logic [ADDR_W-1:0]  rd_loc;
   logic [DATA_W-1:0]  rd_data;
   logic [DATA_W-1:0]  rate_val;
   logic               aux_clr;
   logic               bb_clr;
   logic               launch_req;
   logic [DATA_W-1:0]  regs_v [NUM_LOC];

   assign wr_data    = frm[FRAME_W-1:ADDR_W];
   assign wr_loc     = frm[ADDR_W-1:0];
   assign launch_req = frm_vld &&
                       ((wr_loc == ADDR_W'(LOC_PTR_A)) || (wr_loc == ADDR_W'(LOC_PTR_B)));

   ser_sclk_gen #(
      .RATE_W     (DATA_W),
      .RESET_RATE (RATE_RESET)
   ) u_sclk (
      .clk      (clk),
      .rst_n    (rst_n),
      .rate     (rate_val),
      .sclk     (sclk_o),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb)
   );

   ser_frame_rx #(
      .FRAME_W (FRAME_W)
   ) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .sample_en (rise_stb),
      .fs        (rx_fs),
      .sd        (rx_sd),
      .frm_vld   (frm_vld),
      .frm       (frm)
   );

   ser_reg_file #(
      .DATA_W      (DATA_W),
      .ADDR_W      (ADDR_W),
      .NUM_LOC     (NUM_LOC),
      .AUX_RST_CYC (AUX_RST_CYC),
      .BB_RST_CYC  (BB_RST_CYC),
      .RATE_RESET  (RATE_RESET),
      .RATE_LOC    (RATE_LOC)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_vld   (frm_vld),
      .wr_loc   (wr_loc),
      .wr_data  (wr_data),
      .rd_loc   (rd_loc),
      .rd_data  (rd_data),
      .rate_val (rate_val),
      .aux_clr  (aux_clr),
      .bb_clr   (bb_clr),
      .regs_v   (regs_v)
   );

   ser_frame_tx #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .RD_DELAY (RD_DELAY)
   ) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (launch_req),
      .req_loc  (wr_data[ADDR_W-1:0]),
      .shift_en (fall_stb),
      .rd_data  (rd_data),
      .rd_loc   (rd_loc),
      .tx_fs    (tx_fs),
      .tx_sd    (tx_sd)
   );

endmodule

// File: rtl/ser_reg_if_chk.sv
module ser_reg_if_chk
   import ser_reg_pkg::*;
#(
   parameter int DATA_W   = 10,
   parameter int NUM_LOC  = 27,
   parameter int RD_DELAY = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sclk_o,
   input logic              tx_fs,
   input logic              tx_sd,
   input logic              launch_req,
   input logic              aux_clr,
   input logic              bb_clr,
   input logic [DATA_W-1:0] rate_val,
   input logic [DATA_W-1:0] regs_v [NUM_LOC]
);

   logic [7:0]        gap;
   logic              sclk_d;
   logic              tog;
   logic              tog_seen;
   logic [DATA_W:0]   hcnt;
   logic [DATA_W:0]   hlat;
   logic [DATA_W-1:0] rate_q;
   logic              rst_d;
   logic              aux_zero;
   logic              bb_zero;

   assign tog = (sclk_o != sclk_d);

   always_ff @(posedge clk) rst_d <= rst_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap      <= 8'hFF;
         sclk_d   <= 1'b0;
         tog_seen <= 1'b0;
         hcnt     <= '0;
         hlat     <= '0;
         rate_q   <= '0;
      end else begin
         rate_q <= rate_val;
         sclk_d <= sclk_o;
         if (launch_req)        gap <= 8'h00;
         else if (gap != 8'hFF) gap <= gap + 8'h01;
         if (tog) begin
            tog_seen <= 1'b1;
            hcnt     <= (DATA_W+1)'(1);
            hlat     <= (rate_q == '0) ? (DATA_W+1)'(1) : {1'b0, rate_q};
         end else begin
            hcnt <= hcnt + (DATA_W+1)'(1);
         end
      end
   end

   always_comb begin
      aux_zero = 1'b1;
      bb_zero  = 1'b1;
      for (int k = 0; k < NUM_LOC; k++) begin
         if (class_of(k) == RC_AUX && regs_v[k] != '0) aux_zero = 1'b0;
         if (class_of(k) == RC_BB  && regs_v[k] != '0) bb_zero  = 1'b0;
      end
   end

   p_sd_stable_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk_o) |-> $stable(tx_sd));

   p_fs_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_fs) |-> $fell(sclk_o));

   p_launch_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_fs) |-> (gap >= 8'(RD_DELAY)));

   p_rate_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && !rst_d) |-> (regs_v[LOC_RATE_A] == DATA_W'(4) &&
                             regs_v[LOC_RATE_B] == DATA_W'(4) && aux_zero && bb_zero));

   p_half_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tog && tog_seen) |-> (hcnt == hlat));

   p_aux_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      aux_clr |=> aux_zero);

   p_bb_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bb_clr |=> bb_zero);

   p_soft_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (aux_clr || bb_clr) |=> ($stable(regs_v[LOC_PTR_A]) && $stable(regs_v[LOC_PTR_B]) &&
                              $stable(regs_v[LOC_RATE_A]) && $stable(regs_v[LOC_RATE_B])));

endmodule

bind ser_reg_if ser_reg_if_chk #(
   .DATA_W   (DATA_W),
   .NUM_LOC  (NUM_LOC),
   .RD_DELAY (RD_DELAY)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sclk_o     (sclk_o),
   .tx_fs      (tx_fs),
   .tx_sd      (tx_sd),
   .launch_req (launch_req),
   .aux_clr    (aux_clr),
   .bb_clr     (bb_clr),
   .rate_val   (rate_val),
   .regs_v     (regs_v)
);

// File: tb/ser_reg_if_bench.sv
module ser_reg_if_bench;

   logic clk   = 1'b0;
   logic rst_n = 1'b0;
   logic rx_fs = 1'b0;
   logic rx_sd = 1'b0;
   logic sclk_o;
   logic tx_fs;
   logic tx_sd;

   always #2 clk = ~clk;

   ser_reg_if u_ser_reg_if (
      .clk    (clk),
      .rst_n  (rst_n),
      .sclk_o (sclk_o),
      .rx_fs  (rx_fs),
      .rx_sd  (rx_sd),
      .tx_fs  (tx_fs),
      .tx_sd  (tx_sd)
   );

   int          checks = 0;
   int          errors = 0;
   bit          done   = 0;
   int          model [64];
   logic [15:0] expq [$];
   string       tagq [$];

   function automatic bit mapped(int a);
      case (a)
         3, 4, 7, 8, 9, 10, 12, 18, 19, 20, 21, 25, 26: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic check(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send(int d, int a);
      logic [15:0] f;
      f = {d[9:0], a[5:0]};
      for (int i = 15; i >= 0; i--) begin
         @(negedge sclk_o);
         rx_fs = (i == 15);
         rx_sd = f[i];
      end
      @(negedge sclk_o);
      rx_fs = 1'b0;
      rx_sd = 1'b0;
   endtask

   task automatic wr(int a, int d);
      if (mapped(a)) begin
         if (a == 19 && d[0]) begin
            model[12] = 0; model[18] = 0; model[19] = 0;
         end else if (a == 20 && d[7]) begin
            model[3] = 0; model[4] = 0; model[7] = 0;
            model[8] = 0; model[20] = 0; model[21] = 0;
         end else begin
            model[a] = d & 1023;
         end
      end
      send(d, a);
   endtask

   task automatic rd(int t, string tag, int via = 10);
      int          dexp;
      logic [15:0] e;
      model[via] = t & 63;
      dexp = (t < 27 && mapped(t)) ? model[t] : 0;
      e = {dexp[9:0], t[5:0]};
      expq.push_back(e);
      tagq.push_back(tag);
      send((10 << 6) | (t & 63), via);
      while (expq.size() != 0) @(posedge clk);
   endtask

   task automatic meas(int exp_clk, string tag);
      realtime t0;
      int      got;
      @(posedge sclk_o);
      @(posedge sclk_o);
      t0 = $realtime;
      @(posedge sclk_o);
      got = int'(($realtime - t0) / 4.0);
      check(got == exp_clk, tag, got, exp_clk);
   endtask

   // Monitor: captures reply frames and compares with the scoreboard
   initial begin
      forever begin
         @(posedge sclk_o);
         #1;
         if (tx_fs === 1'b1) begin : cap
            logic [15:0] got;
            logic [15:0] e;
            string       tg;
            bit          fs_bad;
            fs_bad  = 1'b0;
            got[15] = tx_sd;
            for (int i = 14; i >= 0; i--) begin
               @(posedge sclk_o);
               #1;
               got[i] = tx_sd;
               if (tx_fs !== 1'b0) fs_bad = 1'b1;
            end
            if (expq.size() == 0) begin
               check(1'b0, "R3 unexpected reply frame", int'(got), 0);
            end else begin
               e  = expq.pop_front();
               tg = tagq.pop_front();
               check(got == e, tg, int'(got), int'(e));
               check(!fs_bad, "R4 reply frame sync beyond first bit", int'(fs_bad), 0);
            end
         end
      end
   end

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R4 watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < 64; k++) model[k] = 0;
      model[25] = 4;
      model[26] = 4;

      repeat (5) @(posedge clk);
      #1;
      check(tx_fs == 1'b0, "R5 tx_fs low in reset", int'(tx_fs), 0);
      check(tx_sd == 1'b0, "R5 tx_sd low in reset", int'(tx_sd), 0);
      check(sclk_o == 1'b0, "R5 sclk low in reset", int'(sclk_o), 0);
      rst_n = 1'b1;

      // Reset values and default divider
      meas(8, "R6 default serial period");
      rd(3,  "R5 location 3 resets to zero");
      rd(25, "R5 location 25 resets to 4");
      rd(26, "R5 location 26 resets to 4");

      // Plain writes and read-back frame format
      wr(3, 'h2A5);
      wr(4, 'h15A);
      wr(12, 'h3FF);
      wr(18, 'h004);
      wr(21, 'h155);
      wr(25, 'h007);
      rd(3,  "R1 R2 location 3 data and frame layout");
      rd(4,  "R2 location 4");
      rd(12, "R2 location 12");
      rd(18, "R2 location 18");
      rd(21, "R2 location 21");

      // Reserved and out-of-range
      wr(5, 'h123);
      wr(30, 'h0FF);
      rd(5,  "R2 reserved write ignored");
      rd(30, "R3 out-of-range returns zero");
      rd(40, "R3 unmapped target returns zero");
      rd(10, "R3 pointer register reads its own value");
      rd(4,  "R3 read through pointer at 9", 9);
      rd(9,  "R2 pointer keeps six bits");

      // Auxiliary soft reset
      wr(19, 'h2A1);
      rd(12, "R7 aux clear location 12");
      rd(18, "R7 aux clear location 18");
      rd(19, "R9 aux trigger reads zero");
      rd(3,  "R9 aux reset leaves baseband class");
      rd(25, "R9 aux reset leaves rate register");
      wr(19, 'h3FE);
      rd(19, "R2 location 19 stores without trigger");

      // Baseband soft reset
      wr(12, 'h0AA);
      wr(7,  'h111);
      wr(20, 'h081);
      rd(3,  "R8 bb clear location 3");
      rd(7,  "R8 bb clear location 7");
      rd(21, "R8 bb clear location 21");
      rd(20, "R9 bb trigger reads zero");
      rd(12, "R9 bb reset leaves aux class");
      rd(25, "R9 bb reset leaves rate register");
      wr(20, 'h07F);
      rd(20, "R2 location 20 stores without trigger");

      // Divider
      wr(26, 2);
      meas(4, "R6 rate 2 serial period");
      rd(26, "R6 rate register reads 2");
      wr(25, 1);
      meas(4, "R6 location 25 does not drive divider");
      wr(26, 0);
      meas(2, "R6 rate 0 acts as 1");
      rd(18, "R1 round trip at fastest rate");
      wr(26, 4);
      meas(8, "R6 rate restored");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule